// File: doc/BRIEF.md
# Card Data FIFO with Direction Status Flags

This block is the 32-word by 32-bit staging buffer between a register bus and the data path of a memory-card host. It works in one direction at a time. In transmit mode, software or DMA writes words through the bus and the card data path draws them out. In receive mode, the data path deposits words and the bus drains them. Any byte address inside one aligned 32-word window reaches the FIFO data port, so a burst may step through the window or repeat one address.

The block keeps a 6-bit occupancy count and derives registered level flags for each direction from it. A threshold flag for each direction drives a DMA request. Two sticky error bits record starvation (transmit) and overflow (receive) seen on the data-path side, and a write to the clear strobe with a bit mask drops them. Taking the enable low returns both pointers to zero and holds every status output low.

Top module: `cfifo_top`

## Requirements
- R1: The FIFO holds 32 words. The full flag of the active direction is high exactly when 32 words are stored, and a bus write in transmit mode while full is dropped.
- R2: The empty flag of the active direction is high when no word is stored, and its data-available flag is always the opposite of its empty flag while the block is enabled.
- R3: In transmit mode, the half-empty flag is high when 8 or more words are free (count of 24 or less), and `dma_req` follows it.
- R4: In receive mode, the half-full flag is high when 8 or more words are stored, and `dma_req` follows it.
- R5: In transmit mode, a data-path request (`dp_rd`) while the FIFO is empty sets the sticky `tx_underrun` flag and moves no pointer.
- R6: In receive mode, a data-path word (`dp_wr`) offered while the FIFO is full sets the sticky `rx_overrun` flag and is not stored.
- R7: A `clr_wr` pulse clears `tx_underrun` when `clr_mask[0]` is 1 and `rx_overrun` when `clr_mask[1]` is 1. An error event in the same cycle as its clear leaves the flag set.
- R8: With `en` low, the read and write pointers return to zero and every status output, including the error flags, is low in the following cycle.
- R9: A bus access reaches the FIFO when the byte address lies in the 128-byte aligned window at parameter `BASE`, whatever its low seven bits are. Accesses outside the window have no effect.
- R10: `rx_active` is high in the cycle after a data-path write in receive mode while enabled, and low otherwise.
- R11: Level flags are registered and show the occupancy produced by the accesses of the previous cycle. A push and a pop in the same cycle leave the count unchanged.
- R12: Words leave in the order they entered. `bus_rdata` and `dp_rdata` always show the word at the current read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | FIFO enable; low resets the pointers and drops all flags |
| dir_rx | input | 1 | Direction: 0 transmit, 1 receive |
| bus_addr | input | 12 | Bus byte address |
| bus_wr | input | 1 | Bus write strobe (transmit push) |
| bus_wdata | input | 32 | Bus write data |
| bus_rd | input | 1 | Bus read strobe (receive pop) |
| bus_rdata | output | 32 | Word at the read pointer |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_mask | input | 2 | Bit 0 clears underrun, bit 1 clears overrun |
| dp_wr | input | 1 | Data path presents a received word |
| dp_wdata | input | 32 | Received word |
| dp_rd | input | 1 | Data path takes a word to transmit |
| dp_rdata | output | 32 | Word at the read pointer |
| tx_full | output | 1 | Transmit: 32 words stored |
| tx_empty | output | 1 | Transmit: no word stored |
| tx_avail | output | 1 | Transmit: data available |
| tx_half_empty | output | 1 | Transmit: 8 or more words free |
| rx_full | output | 1 | Receive: 32 words stored |
| rx_empty | output | 1 | Receive: no word stored |
| rx_avail | output | 1 | Receive: data available |
| rx_half_full | output | 1 | Receive: 8 or more words stored |
| tx_underrun | output | 1 | Sticky transmit starvation error |
| rx_overrun | output | 1 | Sticky receive overflow error |
| rx_active | output | 1 | Receive data being written |
| dma_req | output | 1 | Threshold request of the active direction |

## Verification
The assertions check, on every cycle, the relationships among the status outputs. Available is the inverse of empty, full and empty are never high together, flags are low after a disabled cycle, errors stay set until a matching clear, and an overflowing receive write raises the overrun flag. Only the directed scenarios can show the exact threshold crossings at 24 and 8 words, the first-in first-out data order, and the rejection of out-of-window and overflowing accesses. They also show that a disable followed by a re-enable really restarts both pointers from zero.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

    localparam int unsigned FIFO_DEPTH = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LEVEL_MARK = 8;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    // level flags of one direction
    typedef struct packed {
        logic full;
        logic empty;
        logic avail;
        logic level;
    } lvl_flags_t;

    // per-cycle decisions of the access controller
    typedef struct packed {
        logic push;
        logic pop;
        logic underrun_ev;
        logic overrun_ev;
    } xfer_t;

    function automatic lvl_flags_t calc_lvl(int unsigned cnt, int unsigned depth,
                                            int unsigned mark, dir_e d);
        lvl_flags_t f;
        f.full  = (cnt == depth);
        f.empty = (cnt == 0);
        f.avail = (cnt != 0);
        if (d == DIR_TX) f.level = ((depth - cnt) >= mark);
        else             f.level = (cnt >= mark);
        return f;
    endfunction

endpackage

// File: rtl/cfifo_ctrl.sv
module cfifo_ctrl
    import cfifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          en,
    input  dir_e          dir,
    input  logic          bus_hit,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          dp_wr,
    input  logic          dp_rd,
    input  logic [CW-1:0] count,
    output xfer_t         xf
);

    logic is_full;
    logic is_empty;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);

    always_comb begin
        xf = '0;
        if (en) begin
            if (dir == DIR_TX) begin
                xf.push        = bus_wr & bus_hit & ~is_full;
                xf.pop         = dp_rd & ~is_empty;
                xf.underrun_ev = dp_rd & is_empty;
            end else begin
                xf.push        = dp_wr & ~is_full;
                xf.pop         = bus_rd & bus_hit & ~is_empty;
                xf.overrun_ev  = dp_wr & is_full;
            end
        end
    end

endmodule

// File: rtl/cfifo_ptrs.sv
module cfifo_ptrs
    import cfifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  xfer_t         xf,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next
);

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        count_next = count;
        case ({xf.push, xf.pop})
            2'b10:   count_next = count + 1'b1;
            2'b01:   count_next = count - 1'b1;
            default: count_next = count;
        endcase
        if (!en) count_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (xf.push) wr_ptr <= bump(wr_ptr);
            if (xf.pop)  rd_ptr <= bump(rd_ptr);
            count <= count_next;
        end
    end

endmodule

// File: rtl/cfifo_mem.sv
module cfifo_mem
    import cfifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned DW    = DATA_W,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && waddr == PW'(g)) cells[g] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/cfifo_status.sv
module cfifo_status
    import cfifo_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned MARK  = LEVEL_MARK,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  dir_e          dir,
    input  logic [CW-1:0] count_next,
    input  xfer_t         xf,
    input  logic          dp_wr,
    input  logic          clr_wr,
    input  logic [1:0]    clr_mask,
    output lvl_flags_t    tx_f,
    output lvl_flags_t    rx_f,
    output logic          underrun,
    output logic          overrun,
    output logic          rx_act
);

    lvl_flags_t nxt;

    assign nxt = calc_lvl(int'(count_next), DEPTH, MARK, dir);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tx_f     <= '0;
            rx_f     <= '0;
            underrun <= 1'b0;
            overrun  <= 1'b0;
            rx_act   <= 1'b0;
        end else begin
            tx_f     <= (dir == DIR_TX) ? nxt : '0;
            rx_f     <= (dir == DIR_RX) ? nxt : '0;
            underrun <= (underrun & ~(clr_wr & clr_mask[0])) | xf.underrun_ev;
            overrun  <= (overrun  & ~(clr_wr & clr_mask[1])) | xf.overrun_ev;
            rx_act   <= (dir == DIR_RX) & dp_wr;
        end
    end

endmodule

// File: rtl/cfifo_top.sv
module cfifo_top
    import cfifo_pkg::*;
#(
    parameter int unsigned DEPTH  = FIFO_DEPTH,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned MARK   = LEVEL_MARK,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h080,
    localparam int unsigned PW      = $clog2(DEPTH),
    localparam int unsigned CW      = PW + 1,
    localparam int unsigned WIN_LSB = $clog2(DEPTH * DW / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dir_rx,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic              clr_wr,
    input  logic [1:0]        clr_mask,
    input  logic              dp_wr,
    input  logic [DW-1:0]     dp_wdata,
    input  logic              dp_rd,
    output logic [DW-1:0]     dp_rdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_avail,
    output logic              tx_half_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_avail,
    output logic              rx_half_full,
    output logic              tx_underrun,
    output logic              rx_overrun,
    output logic              rx_active,
    output logic              dma_req
);

    localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << WIN_LSB) - 1'b1);

    dir_e          dir;
    logic          bus_hit;
    xfer_t         xf;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] count_next;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    lvl_flags_t    tx_f;
    lvl_flags_t    rx_f;

    assign dir     = dir_e'(dir_rx);
    assign bus_hit = (((bus_addr ^ BASE) & WIN_MASK) == '0);
    assign wdata   = (dir == DIR_TX) ? bus_wdata : dp_wdata;

    cfifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .en      (en),
        .dir     (dir),
        .bus_hit (bus_hit),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .dp_wr   (dp_wr),
        .dp_rd   (dp_rd),
        .count   (count),
        .xf      (xf)
    );

    cfifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .xf         (xf),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (count),
        .count_next (count_next)
    );

    cfifo_mem #(.DEPTH(DEPTH), .DW(DW)) mem_i (
        .clk   (clk),
        .we    (xf.push),
        .waddr (wr_ptr),
        .wdata (wdata),
        .raddr (rd_ptr),
        .rdata (rdata)
    );

    cfifo_status #(.DEPTH(DEPTH), .MARK(MARK)) status_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .dir        (dir),
        .count_next (count_next),
        .xf         (xf),
        .dp_wr      (dp_wr),
        .clr_wr     (clr_wr),
        .clr_mask   (clr_mask),
        .tx_f       (tx_f),
        .rx_f       (rx_f),
        .underrun   (tx_underrun),
        .overrun    (rx_overrun),
        .rx_act     (rx_active)
    );

    assign bus_rdata     = rdata;
    assign dp_rdata      = rdata;
    assign tx_full       = tx_f.full;
    assign tx_empty      = tx_f.empty;
    assign tx_avail      = tx_f.avail;
    assign tx_half_empty = tx_f.level;
    assign rx_full       = rx_f.full;
    assign rx_empty      = rx_f.empty;
    assign rx_avail      = rx_f.avail;
    assign rx_half_full  = rx_f.level;
    assign dma_req       = tx_f.level | rx_f.level;

endmodule

// File: rtl/cfifo_chk.sv
module cfifo_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       dir_rx,
    input logic       dp_wr,
    input logic       clr_wr,
    input logic [1:0] clr_mask,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       tx_avail,
    input logic       rx_full,
    input logic       rx_empty,
    input logic       rx_avail,
    input logic       tx_underrun,
    input logic       rx_overrun,
    input logic       rx_active,
    input logic       dma_req
);

    // R2
    tx_avail_inv_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(dir_rx)) |-> (tx_avail != tx_empty));

    // R2
    rx_avail_inv_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(dir_rx)) |-> (rx_avail != rx_empty));

    // R1
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !(tx_full || tx_empty || tx_avail || rx_full || rx_empty ||
                         rx_avail || tx_underrun || rx_overrun || rx_active || dma_req));

    // R5
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_underrun && en && !(clr_wr && clr_mask[0])) |=> tx_underrun);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && en && !(clr_wr && clr_mask[1])) |=> rx_overrun);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir_rx && dp_wr && rx_full) |=> rx_overrun);

    // R10
    rx_active_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir_rx && dp_wr) |=> rx_active);

endmodule

bind cfifo_top cfifo_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .dir_rx      (dir_rx),
    .dp_wr       (dp_wr),
    .clr_wr      (clr_wr),
    .clr_mask    (clr_mask),
    .tx_full     (tx_full),
    .tx_empty    (tx_empty),
    .tx_avail    (tx_avail),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .rx_avail    (rx_avail),
    .tx_underrun (tx_underrun),
    .rx_overrun  (rx_overrun),
    .rx_active   (rx_active),
    .dma_req     (dma_req)
);

// File: tb/cfifo_top_tb_top.sv
module cfifo_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] BASE = 12'h080;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        dir_rx;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        clr_wr;
    logic [1:0]  clr_mask;
    logic        dp_wr;
    logic [31:0] dp_wdata;
    logic        dp_rd;
    logic [31:0] dp_rdata;
    logic tx_full, tx_empty, tx_avail, tx_half_empty;
    logic rx_full, rx_empty, rx_avail, rx_half_full;
    logic tx_underrun, rx_overrun, rx_active, dma_req;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfifo_top dut_i (
        .clk(clk), .rst(rst), .en(en), .dir_rx(dir_rx),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .clr_wr(clr_wr), .clr_mask(clr_mask),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd), .dp_rdata(dp_rdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_avail(tx_avail),
        .tx_half_empty(tx_half_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_avail(rx_avail),
        .rx_half_full(rx_half_full),
        .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
        .rx_active(rx_active), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_pull(input logic [11:0] a, output logic [31:0] d);
        d = bus_rdata;
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic dp_push(input logic [31:0] d);
        dp_wdata = d; dp_wr = 1'b1;
        step();
        dp_wr = 1'b0;
    endtask

    task automatic dp_pull(output logic [31:0] d);
        d = dp_rdata;
        dp_rd = 1'b1;
        step();
        dp_rd = 1'b0;
    endtask

    task automatic restart(input logic rx);
        en = 1'b0;
        step();
        dir_rx = rx; en = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R8 reset flags", {tx_full, tx_empty, tx_avail, tx_half_empty, rx_full, rx_empty,
            rx_avail, rx_half_full, tx_underrun, rx_overrun, rx_active, dma_req}, 0);
    endtask

    task automatic t_tx_fill_drain();
        logic [31:0] d;
        restart(1'b0);
        chk("R2 tx empty at start", {tx_empty, tx_avail, tx_full}, 3'b100);
        chk("R3 half-empty when empty", {tx_half_empty, dma_req}, 2'b11);
        for (int i = 0; i < 32; i++) begin
            bus_write(BASE + 12'(4 * i), 32'hA000_0000 + i);
            chk("R1 tx full only at 32", tx_full, (i == 31));
            chk("R2 tx avail", {tx_avail, tx_empty}, 2'b10);
            if (i == 23 || i == 24)
                chk("R3 tx half-empty edge", {tx_half_empty, dma_req}, (i == 23) ? 2'b11 : 2'b00);
        end
        bus_write(BASE, 32'hDEAD_BEEF);
        chk("R1 write when full dropped", tx_full, 1);
        for (int i = 0; i < 32; i++) begin
            dp_pull(d);
            chk("R12 tx order", d, 32'hA000_0000 + i);
        end
        chk("R2 tx empty after drain", {tx_empty, tx_avail}, 2'b10);
        chk("R1 no extra word stored", tx_underrun, 0);
    endtask

    task automatic t_underrun();
        logic [31:0] d;
        dp_rd = 1'b1;
        step();
        dp_rd = 1'b0;
        chk("R5 underrun set", tx_underrun, 1);
        chk("R5 still empty", tx_empty, 1);
        bus_write(BASE + 12'h10, 32'h0000_0055);
        dp_pull(d);
        chk("R5 pointers unmoved", d, 32'h0000_0055);
        chk("R5 underrun sticky", tx_underrun, 1);
    endtask

    task automatic t_clear();
        clr_wr = 1'b1; clr_mask = 2'b10;
        step();
        clr_wr = 1'b0;
        chk("R7 other mask bit keeps underrun", tx_underrun, 1);
        clr_wr = 1'b1; clr_mask = 2'b01; dp_rd = 1'b1;
        step();
        clr_wr = 1'b0; dp_rd = 1'b0;
        chk("R7 event beats clear", tx_underrun, 1);
        clr_wr = 1'b1; clr_mask = 2'b01;
        step();
        clr_wr = 1'b0;
        chk("R7 clear underrun", tx_underrun, 0);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        en = 1'b0;
        step();
        t_reset();
        dir_rx = 1'b1; en = 1'b1;
        step();
        chk("R2 rx empty, tx flags low", {rx_empty, rx_avail, tx_empty}, 3'b100);
        for (int i = 0; i < 32; i++) begin
            dp_push(32'hB000_0000 + i);
            if (i == 0) chk("R10 rx active", rx_active, 1);
            if (i == 6 || i == 7)
                chk("R4 rx half-full edge", {rx_half_full, dma_req}, (i == 7) ? 2'b11 : 2'b00);
            chk("R1 rx full only at 32", rx_full, (i == 31));
        end
        step();
        chk("R10 rx active drops", rx_active, 0);
        dp_push(32'hDEAD_BEEF);
        chk("R6 overrun set", {rx_overrun, rx_full}, 2'b11);
        bus_pull(BASE + 12'h080, d);
        chk("R9 outside read ignored", {rx_full, 1'b0}, 2'b10);
        chk("R12 rdata at read pointer", bus_rdata, 32'hB000_0000);
        for (int i = 0; i < 32; i++) begin
            bus_pull(BASE + 12'(4 * ((i * 7) % 32) + (i % 4)), d);
            chk("R9 any window address reads", d, 32'hB000_0000 + i);
        end
        chk("R6 overflow word not stored", {rx_empty, rx_avail}, 2'b10);
        chk("R6 overrun sticky", rx_overrun, 1);
        clr_wr = 1'b1; clr_mask = 2'b10;
        step();
        clr_wr = 1'b0;
        chk("R7 clear overrun", rx_overrun, 0);
    endtask

    task automatic t_window_simul();
        restart(1'b0);
        bus_write(BASE + 12'h080, 32'h1111_1111);
        bus_write(BASE - 12'h004, 32'h2222_2222);
        chk("R9 outside writes ignored", tx_empty, 1);
        for (int i = 0; i < 24; i++) bus_write(BASE + 12'h7C, 32'hC000_0000 + i);
        chk("R11 count 24 half-empty", tx_half_empty, 1);
        bus_addr = BASE; bus_wdata = 32'hC000_0018; bus_wr = 1'b1; dp_rd = 1'b1;
        step();
        bus_wr = 1'b0; dp_rd = 1'b0;
        chk("R11 push+pop keeps count", tx_half_empty, 1);
        bus_write(BASE, 32'hC000_0019);
        chk("R11 count 25 crosses", tx_half_empty, 0);
        chk("R12 read port after pop", dp_rdata, 32'hC000_0001);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        en = 1'b0;
        step();
        chk("R8 disabled flags low", {tx_empty, tx_avail, tx_half_empty, dma_req}, 0);
        en = 1'b1;
        step();
        chk("R8 re-enable empty", {tx_empty, tx_avail}, 2'b10);
        bus_write(BASE, 32'hD000_0000);
        dp_pull(d);
        chk("R8 pointers restart at zero", d, 32'hD000_0000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; dir_rx = 1'b0;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        clr_wr = 1'b0; clr_mask = '0;
        dp_wr = 1'b0; dp_wdata = '0; dp_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_tx_fill_drain();
        t_underrun();
        t_clear();
        t_rx();
        t_window_simul();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule